// File: doc/BRIEF.md
# SPI Slave Memory Command Front-End

This block is an SPI slave that gives a host serial access to a byte-wide on-chip memory. The space is 15 bits wide (32K locations). In simulation, the physical array can be built smaller, and the low address bits pick the location. After chip select falls, the first byte is a command. Read and write commands then take a two-byte address, and after that data streams in or out for as long as chip select stays low. Separate commands set and clear a write-enable latch, and read and write an 8-bit status byte.

The pins `csN`, `sck` and `si` are oversampled by a faster system clock through two-flop synchronisers. Serial clock edges are found from the synchronised samples, so the system clock must run at least four times faster than `sck`. The serial output is driven together with an output enable, which the pad logic turns into a tri-state driver. Any unknown command locks the slave out until chip select falls again.

Top module: `spi_mem_slave`

## Requirements
- R1: In both mode 0 (sck idles low) and mode 3 (sck idles high), `si` is sampled on rising `sck` edges and `so` changes only after falling `sck` edges.
- R2: Every byte is shifted most significant bit first. The first byte after chip select falls is the command, and only one command is accepted per chip-select assertion: later bytes are never decoded as commands.
- R3: The command codes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory). Any other code locks the slave out: `soEn` stays low and `si` is ignored until the next chip-select falling edge.
- R4: Read and write memory take a two-byte address after the command. The first address bit received is ignored, so only 15 bits select a location.
- R5: After each data byte the address advances by one. It wraps from 0x7FFF to 0x0000 while chip select stays low.
- R6: Status bit 1 is the write-enable latch. Command 0x06 sets it and 0x04 clears it. Memory and status writes have no effect while the latch is clear.
- R7: The write-enable latch clears when chip select rises after a write memory or write status command has reached its data phase.
- R8: The status byte reads as {bits 7:2 writable, bit 1 latch, bit 0 = 0}. Write status updates only bits 7:2. The status byte is 0x00 after reset.
- R9: A write data byte is stored only once all 8 bits have arrived. A byte cut short by chip select rising is discarded.
- R10: While chip select is high, `soEn` is low and `si` and `sck` activity has no effect.
- R11: Read status keeps returning the status byte for every further byte clocked while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the sck rate |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| soEn | output | 1 | Output enable for the tri-state driver of `so` |

## Verification
The checker assumes that `csN` has been held high for several system clocks before its windows start. It also assumes that `csN` and `sck` never change within a cycle or two of each other, so the synchronisers keep their order. The bench drives every pin on falling `clk` edges and holds each `sck` phase for eight system clocks (16x oversampling). It moves `csN` only while `sck` sits at its idle level for that mode, with several clocks of margin. The master samples `so` at the rising `sck` edge, a full half-period after the falling edge, so the synchroniser delay never reaches the sampling point.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] CMD_SET_WEL  = 8'h06;
  localparam logic [7:0] CMD_CLR_WEL  = 8'h04;
  localparam logic [7:0] CMD_RD_STAT  = 8'h05;
  localparam logic [7:0] CMD_WR_STAT  = 8'h01;
  localparam logic [7:0] CMD_RD_MEM   = 8'h03;
  localparam logic [7:0] CMD_WR_MEM   = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_ADDR_HI, PH_ADDR_LO,
    PH_RD_MEM, PH_WR_MEM, PH_RD_STAT, PH_WR_STAT,
    PH_IGNORE, PH_LOCKED
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic addrHiLd;
    logic addrLoLd;
    logic addrInc;
    logic memWr;
    logic statWr;
    logic welSet;
    logic welClr;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
    logic outEn;
  } strobe_t;
endpackage

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic [7:0] rxByte,
  output logic       siBit,
  output strobe_t    strb
);
  logic [SYNC_STAGES-1:0] csSync, sckSync, siSync;
  logic csS, sckS, csPrev, sckPrev;
  logic sel, csFall, csRise, sckRise, sckFall, byteDone;
  logic [2:0] bitCnt;
  logic isWrite;
  phase_t phase, phaseNext;

  // two-flop style synchronisers, depth set by SYNC_STAGES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= '1;
      sckSync <= '0;
      siSync  <= '0;
    end else begin
      csSync  <= {csSync[SYNC_STAGES-2:0], csN};
      sckSync <= {sckSync[SYNC_STAGES-2:0], sck};
      siSync  <= {siSync[SYNC_STAGES-2:0], si};
    end
  end

  assign csS   = csSync[SYNC_STAGES-1];
  assign sckS  = sckSync[SYNC_STAGES-1];
  assign siBit = siSync[SYNC_STAGES-1];

  assign sel      = ~csS;
  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sckRise  = sel & sckS & ~sckPrev;
  assign sckFall  = sel & ~sckS & sckPrev;
  assign byteDone = sckRise && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
      bitCnt  <= '0;
      isWrite <= 1'b0;
      phase   <= PH_IDLE;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
      if (csRise) begin
        phase <= PH_IDLE;
      end else if (csFall) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
      end else begin
        if (sckRise) bitCnt <= bitCnt + 3'd1;
        if (byteDone && phase == PH_CMD) isWrite <= (rxByte == CMD_WR_MEM);
        phase <= phaseNext;
      end
    end
  end

  always_comb begin
    strb         = '0;
    phaseNext    = phase;
    strb.shiftIn = sckRise;
    case (phase)
      PH_CMD: if (byteDone) begin
        case (rxByte)
          CMD_SET_WEL: begin strb.welSet = 1'b1; phaseNext = PH_IGNORE; end
          CMD_CLR_WEL: begin strb.welClr = 1'b1; phaseNext = PH_IGNORE; end
          CMD_RD_STAT: phaseNext = PH_RD_STAT;
          CMD_WR_STAT: phaseNext = PH_WR_STAT;
          CMD_RD_MEM, CMD_WR_MEM: phaseNext = PH_ADDR_HI;
          default:     phaseNext = PH_LOCKED;
        endcase
      end
      PH_ADDR_HI: if (byteDone) begin
        strb.addrHiLd = 1'b1;
        phaseNext     = PH_ADDR_LO;
      end
      PH_ADDR_LO: if (byteDone) begin
        strb.addrLoLd = 1'b1;
        phaseNext     = isWrite ? PH_WR_MEM : PH_RD_MEM;
      end
      PH_RD_MEM: begin
        strb.outEn = sel;
        if (sckFall && bitCnt == 3'd0) begin
          strb.txLoadMem = 1'b1;
          strb.addrInc   = 1'b1;
        end else if (sckFall) begin
          strb.txShift = 1'b1;
        end
      end
      PH_RD_STAT: begin
        strb.outEn = sel;
        if (sckFall && bitCnt == 3'd0) strb.txLoadStat = 1'b1;
        else if (sckFall)              strb.txShift    = 1'b1;
      end
      PH_WR_MEM: if (byteDone) begin
        strb.memWr   = 1'b1;
        strb.addrInc = 1'b1;
      end
      PH_WR_STAT: if (byteDone) strb.statWr = 1'b1;
      default: ;
    endcase
    if (csRise && (phase == PH_WR_MEM || phase == PH_WR_STAT)) strb.welClr = 1'b1;
  end
endmodule

// File: rtl/spi_mem_dpath.sv
module spi_mem_dpath
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       siBit,
  output logic [7:0] rxByte,
  output logic       so,
  output logic       soEn
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int HI_W      = ADDR_W - 8;

  logic [6:0]        rxSh;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem [MEM_DEPTH];
  logic [5:0]        statHi;
  logic              wel;
  logic [7:0]        txSh;
  logic [7:0]        statusByte;
  logic [MEM_AW-1:0] memIdx;

  assign rxByte     = {rxSh, siBit};
  assign statusByte = {statHi, wel, 1'b0};
  assign memIdx     = addr[MEM_AW-1:0];
  assign so         = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      addr   <= '0;
      statHi <= '0;
      wel    <= 1'b0;
      txSh   <= '0;
      soEn   <= 1'b0;
    end else begin
      soEn <= strb.outEn;
      if (strb.shiftIn) rxSh <= rxByte[6:0];
      // first address bit (rxByte[7]) is dropped
      if (strb.addrHiLd)     addr[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      else if (strb.addrLoLd) addr[7:0]       <= rxByte;
      else if (strb.addrInc)  addr            <= addr + 1'b1;
      if (strb.welSet)      wel <= 1'b1;
      else if (strb.welClr) wel <= 1'b0;
      if (strb.statWr && wel) statHi <= rxByte[7:2];
      if (strb.txLoadMem)       txSh <= mem[memIdx];
      else if (strb.txLoadStat) txSh <= statusByte;
      else if (strb.txShift)    txSh <= {txSh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWr && wel) mem[memIdx] <= rxByte;
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic soEn
);
  strobe_t    strb;
  logic       siBit;
  logic [7:0] rxByte;

  spi_mem_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .rxByte(rxByte), .siBit(siBit), .strb(strb)
  );

  spi_mem_dpath #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .siBit(siBit),
    .rxByte(rxByte), .so(so), .soEn(soEn)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    csN,
  input logic    so,
  input logic    soEn,
  input strobe_t strb
);
  p_hiz_deselect_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soEn);

  p_no_shift_deselect_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !strb.shiftIn);

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.memWr, strb.statWr, strb.welSet, strb.welClr,
              strb.addrHiLd, strb.addrLoLd, strb.txLoadMem, strb.txLoadStat}));

  p_so_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (soEn && $past(soEn) &&
     !$past(strb.txLoadMem || strb.txLoadStat || strb.txShift)) |-> $stable(so));
endmodule

bind spi_mem_slave spi_mem_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .so(so), .soEn(soEn), .strb(strb)
);

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, soEn;
  logic rdPhase = 1'b0;
  int   nChecks = 0, nFails = 0;
  logic [7:0] expVal[$];
  string      expTag[$];

  always #5 clk = ~clk;

  spi_mem_slave dut_i (.clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
                       .so(so), .soEn(soEn));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic selBegin(input bit m3);
    sck = m3;
    waitClk(4);
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic selEnd(input bit m3);
    if (!m3) begin sck = 1'b0; waitClk(HALF); end
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = b[i]; waitClk(HALF);
      sck = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic expRead(input logic [7:0] v, input string tag);
    expVal.push_back(v);
    expTag.push_back(tag);
    rdPhase = 1'b1;
    sendBits(8'h00, 8);
    rdPhase = 1'b0;
  endtask

  task automatic cmd(input bit m3, input logic [7:0] op);
    selBegin(m3); sendBits(op, 8); selEnd(m3);
  endtask

  task automatic readStat(input bit m3, input int n, input logic [7:0] e, input string tag);
    selBegin(m3); sendBits(8'h05, 8);
    for (int i = 0; i < n; i++) expRead(e, tag);
    selEnd(m3);
  endtask

  task automatic writeStat(input bit m3, input logic [7:0] v);
    selBegin(m3); sendBits(8'h01, 8); sendBits(v, 8); selEnd(m3);
  endtask

  task automatic writeMem(input bit m3, input logic [15:0] a, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    selBegin(m3); sendBits(8'h02, 8); sendBits(a[15:8], 8); sendBits(a[7:0], 8);
    if (n > 0) sendBits(b0, 8);
    if (n > 1) sendBits(b1, 8);
    if (n > 2) sendBits(b2, 8);
    selEnd(m3);
  endtask

  task automatic readMem(input bit m3, input logic [15:0] a, input int n,
                         input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                         input string tag);
    selBegin(m3); sendBits(8'h03, 8); sendBits(a[15:8], 8); sendBits(a[7:0], 8);
    if (n > 0) expRead(e0, tag);
    if (n > 1) expRead(e1, tag);
    if (n > 2) expRead(e2, tag);
    selEnd(m3);
  endtask

  // monitor: master samples so on rising sck during read phases
  initial begin
    logic [7:0] cap;
    int   bits;
    bit   enOk;
    bits = 0; cap = '0; enOk = 1'b1;
    forever begin
      @(posedge sck);
      if (rdPhase) begin
        cap  = {cap[6:0], so};
        enOk = enOk & soEn;
        bits++;
        if (bits == 8) begin
          if (expVal.size() == 0) begin
            check(1'b0, "R1 unexpected byte", cap, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = expVal.pop_front();
            t = expTag.pop_front();
            check(cap == e && enOk, t, cap, e);
          end
          bits = 0; enOk = 1'b1;
        end
      end
    end
  end

  initial begin
    waitClk(150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    check(soEn == 1'b0, "R10 soEn low after reset", soEn, 0);
    readStat(1'b0, 1, 8'h00, "R8 reset status");

    cmd(1'b0, 8'h06);
    readStat(1'b0, 3, 8'h02, "R11 repeated status with R6 latch set");

    writeMem(1'b0, 16'h0010, 3, 8'hA5, 8'h3C, 8'hF0);
    readStat(1'b1, 1, 8'h00, "R7 latch cleared after write");
    readMem(1'b1, 16'h0010, 3, 8'hA5, 8'h3C, 8'hF0, "R1 R2 R5 mode3 sequential read");

    writeMem(1'b1, 16'h0010, 1, 8'h11, 8'h00, 8'h00);
    readMem(1'b0, 16'h0010, 1, 8'hA5, 8'h00, 8'h00, "R6 write blocked without latch");

    cmd(1'b1, 8'h06);
    writeMem(1'b0, 16'h8020, 1, 8'h77, 8'h00, 8'h00);
    readMem(1'b1, 16'h0020, 1, 8'h77, 8'h00, 8'h00, "R4 top address bit ignored");

    cmd(1'b0, 8'h06);
    writeMem(1'b1, 16'h7FFF, 2, 8'h12, 8'h34, 8'h00);
    readMem(1'b0, 16'h7FFF, 2, 8'h12, 8'h34, 8'h00, "R5 read across wrap");
    readMem(1'b0, 16'h0000, 1, 8'h34, 8'h00, 8'h00, "R5 write wrapped to 0x0000");

    // R3 lockout on invalid code 0xFF, followed by a set-latch pattern
    selBegin(1'b0);
    sendBits(8'hFF, 8);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = (8'h06 >> i) & 1'b1; waitClk(HALF);
      sck = 1'b1;
      check(soEn == 1'b0, "R3 soEn low while locked", soEn, 0);
      waitClk(HALF);
    end
    selEnd(1'b0);
    readStat(1'b0, 1, 8'h00, "R3 bits after invalid code ignored");

    // R2 one command per select
    selBegin(1'b1); sendBits(8'h06, 8); sendBits(8'h04, 8); selEnd(1'b1);
    readStat(1'b1, 1, 8'h02, "R2 second command byte ignored");
    cmd(1'b0, 8'h04);
    readStat(1'b0, 1, 8'h00, "R6 clear latch command");

    cmd(1'b0, 8'h06);
    writeStat(1'b0, 8'hFF);
    readStat(1'b0, 1, 8'hFC, "R8 R7 status write bits 7:2 only");
    writeStat(1'b1, 8'h00);
    readStat(1'b1, 1, 8'hFC, "R6 status write blocked without latch");
    cmd(1'b1, 8'h06);
    writeStat(1'b1, 8'h00);
    readStat(1'b0, 1, 8'h00, "R8 status write cleared bits");

    cmd(1'b0, 8'h06);
    writeMem(1'b0, 16'h0030, 2, 8'h99, 8'h66, 8'h00);
    cmd(1'b0, 8'h06);
    selBegin(1'b0);
    sendBits(8'h02, 8); sendBits(8'h00, 8); sendBits(8'h30, 8);
    sendBits(8'h5A, 8); sendBits(8'hFF, 4);
    selEnd(1'b0);
    readMem(1'b1, 16'h0030, 2, 8'h5A, 8'h66, 8'h00, "R9 partial byte discarded");

    // R10 activity while deselected
    for (int i = 15; i >= 0; i--) begin
      sck = 1'b0; si = (16'h0606 >> i) & 1'b1; waitClk(HALF);
      sck = 1'b1;
      check(soEn == 1'b0, "R10 soEn low while deselected", soEn, 0);
      waitClk(HALF);
    end
    sck = 1'b0; waitClk(HALF);
    readStat(1'b0, 1, 8'h00, "R10 si ignored while deselected");

    waitClk(20);
    check(expVal.size() == 0, "R1 all expected bytes seen", expVal.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule